// File: doc/BRIEF.md
# Multidrop Asynchronous Serial Transceiver

This block is a full-duplex asynchronous serial port with one transmit holding register, one receive holding register and a 16-bit line-control register. Software writes the control word, loads bytes into the transmit holding register, and collects received bytes from the receive holding register. Every serial bit lasts sixteen ticks of a transfer clock. That clock comes from the system clock or from an external clock pin, and either source can be used directly or through a programmable divider.

In normal mode a frame is a low start bit, eight data bits sent least significant first, an optional parity bit and a high stop bit. In multidrop mode, parity is switched off whatever its enable says, and a wake-up bit takes its place. On transmit, that bit comes from a control field. On receive, only frames whose wake-up bit equals the selected value are kept. A node can therefore listen to address frames alone and then switch to data frames. For shared lines the transmit pin can work as open drain: it only pulls low and releases for high.

Top module: `mdrop_uart`

## Requirements
- R1: After reset the line is released high and driven (`txd_oe`=1), `tx_full`=0 and `rx_ready`=0. The control word resets to 0x0080. Its layout is bits [1:0] mode, bit 2 parity enable, bit 3 even-parity select, bits [5:4] clock select, bit 6 open drain, bit 7 transmit wake bit, bit 8 receive wake select, and bits [15:9] divisor minus one.
- R2: With clock select 00 each bit lasts 16 system clocks. A load puts the start bit on the line two clocks later. The frame is: start 0, then data bits 0 to 7, then an optional extra bit, then stop 1.
- R3: With parity enabled in normal mode (mode 00 or 01), the extra bit is the parity bit. With even select it makes the count of ones, parity bit included, even. Otherwise it makes that count odd.
- R4: In multidrop mode (mode bit 1 set), the extra bit is the transmit wake bit, and the parity enable has no effect on transmit or receive.
- R5: A received frame loads `rx_byte` and sets `rx_ready`. A one-clock `rx_read` pulse clears `rx_ready`.
- R6: With parity enabled in normal mode, `rx_parity_err` reports a parity mismatch on the latest accepted frame.
- R7: A low stop bit sets `rx_frame_err` on the frame it belongs to.
- R8: In multidrop mode, a frame whose wake bit differs from the receive wake select is dropped: `rx_byte` keeps its value and `rx_ready` does not rise.
- R9: Clock select 01 gives a tick every divisor+1 system clocks. Select 10 gives a tick per rising edge of `sclk_in`. Select 11 gives a tick every divisor+1 such edges. A bit lasts 16 ticks.
- R10: With open drain set, `txd_o` is 0 and `txd_oe` is 1 exactly while a 0 is sent. Otherwise `txd_oe` is 0.
- R11: A load while the holding register is empty is accepted even if a frame is in flight. It is sent after one idle clock following the current stop bit. A load while `tx_full` is 1 is ignored.
- R12: A low pulse on `rxd` that is gone before the mid-bit sample of the start bit is ignored, and the next frame is received correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk_in | input | 1 | External transfer clock pin |
| lcr_we | input | 1 | Line-control write strobe |
| lcr_wdata | input | 16 | Line-control write value |
| tx_load | input | 1 | Load `tx_byte` into the transmit holding register |
| tx_byte | input | 8 | Byte to transmit |
| tx_full | output | 1 | Transmit holding register occupied |
| txd_o | output | 1 | Transmit data value |
| txd_oe | output | 1 | Transmit output enable |
| rxd | input | 1 | Receive line |
| rx_read | input | 1 | Acknowledge the received byte |
| rx_byte | output | 8 | Receive holding register |
| rx_ready | output | 1 | Unread byte present |
| rx_frame_err | output | 1 | Stop bit of the latest accepted frame was low |
| rx_parity_err | output | 1 | Parity of the latest accepted frame was wrong |

## Verification
The assertions assume that the line-control word is only rewritten while both directions are idle, because the frame layout and the accept rule are read while a frame is under way. They also assume that `sclk_in` is slower than half the system clock, so that every rising edge survives synchronisation. The stimulus rewrites the control word only after the expected transmit stream has drained and the receive line has been high for many bit times. It toggles the external clock every two system clocks.

// File: rtl/mdu_pkg.sv
package mdu_pkg;
    localparam int DIV_W  = 7;
    localparam int BYTE_W = 8;
    localparam int FRM_W  = BYTE_W + 3;
    localparam int BCW    = $clog2(FRM_W);

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic             rx_wake;
        logic             tx_wake;
        logic             od_en;
        logic [1:0]       clk_sel;
        logic             par_even;
        logic             par_en;
        logic [1:0]       mode;
    } lcr_t;

    localparam int   LCR_W   = $bits(lcr_t);
    localparam lcr_t LCR_RST = '{div: '0, rx_wake: 1'b0, tx_wake: 1'b1, od_en: 1'b0,
                                 clk_sel: 2'b00, par_even: 1'b0, par_en: 1'b0, mode: 2'b00};

    typedef enum logic [1:0] {
        CK_BUS     = 2'b00,
        CK_BUS_DIV = 2'b01,
        CK_EXT     = 2'b10,
        CK_EXT_DIV = 2'b11
    } ck_sel_e;

    typedef enum logic {RXS_IDLE, RXS_SHIFT} rx_st_e;

    // Frame-shaping subset of the control word, shared by both directions
    typedef struct packed {
        logic md;
        logic pe;
        logic ev;
        logic wk;
    } fcfg_t;

    typedef struct packed {
        logic present;
        logic value;
    } xbit_t;

    function automatic logic parity_bit(logic [BYTE_W-1:0] d, logic even);
        return (^d) ^ ~even;
    endfunction

    function automatic xbit_t extra_bit(fcfg_t c, logic [BYTE_W-1:0] d);
        xbit_t x;
        if (c.md) begin
            x.present = 1'b1;
            x.value   = c.wk;
        end else begin
            x.present = c.pe;
            x.value   = parity_bit(d, c.ev);
        end
        return x;
    endfunction

    function automatic fcfg_t tx_view(lcr_t c);
        fcfg_t f;
        f.md = c.mode[1];
        f.pe = c.par_en;
        f.ev = c.par_even;
        f.wk = c.tx_wake;
        return f;
    endfunction

    function automatic fcfg_t rx_view(lcr_t c);
        fcfg_t f;
        f.md = c.mode[1];
        f.pe = c.par_en;
        f.ev = c.par_even;
        f.wk = c.rx_wake;
        return f;
    endfunction
endpackage

// File: rtl/mdu_tick_gen.sv
module mdu_tick_gen
    import mdu_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             ext_clk,
    input  logic [1:0]       sel,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [2:0]       ext_sync;
    logic             ext_rise;
    logic             src;
    logic             wrap;
    logic [DIV_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) ext_sync <= '0;
        else     ext_sync <= {ext_sync[1:0], ext_clk};
    end

    assign ext_rise = ext_sync[1] & ~ext_sync[2];
    assign src      = sel[1] ? ext_rise : 1'b1;
    assign wrap     = (cnt >= div);

    always_ff @(posedge clk) begin
        if (rst || !sel[0]) cnt <= '0;
        else if (src)       cnt <= wrap ? '0 : cnt + 1'b1;
    end

    assign tick = sel[0] ? (src & wrap) : src;

    // R9
    div_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && sel == CK_BUS_DIV && div != '0) |=>
            (!tick || !$stable(sel) || !$stable(div)));
endmodule

// File: rtl/mdu_tx.sv
module mdu_tx
    import mdu_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  fcfg_t             fcfg,
    input  logic              load,
    input  logic [BYTE_W-1:0] load_data,
    output logic              full,
    output logic              line
);
    localparam int             TCW    = $clog2(OVS);
    localparam logic [TCW-1:0] T_LAST = TCW'(OVS - 1);
    localparam logic [BCW-1:0] LAST_X = BCW'(FRM_W - 1);
    localparam logic [BCW-1:0] LAST_N = BCW'(FRM_W - 2);

    logic              hold_v;
    logic [BYTE_W-1:0] hold_d;
    logic              busy;
    logic [FRM_W-1:0]  sh;
    logic [FRM_W-1:0]  frame;
    logic [BCW-1:0]    bit_idx;
    logic [BCW-1:0]    last_bit;
    logic [TCW-1:0]    tcnt;
    logic              start_ok;
    xbit_t             xb;

    always_comb begin
        xb = extra_bit(fcfg, hold_d);
        if (xb.present) frame = {1'b1, xb.value, hold_d, 1'b0};
        else            frame = {1'b1, 1'b1, hold_d, 1'b0};
    end

    assign start_ok = !busy && hold_v;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_v   <= 1'b0;
            hold_d   <= '0;
            busy     <= 1'b0;
            sh       <= '1;
            bit_idx  <= '0;
            last_bit <= '0;
            tcnt     <= '0;
        end else begin
            if (start_ok) begin
                busy     <= 1'b1;
                sh       <= frame;
                last_bit <= xb.present ? LAST_X : LAST_N;
                bit_idx  <= '0;
                tcnt     <= '0;
            end else if (busy && tick) begin
                if (tcnt == T_LAST) begin
                    tcnt <= '0;
                    if (bit_idx == last_bit) begin
                        busy <= 1'b0;
                    end else begin
                        bit_idx <= bit_idx + 1'b1;
                        sh      <= {1'b1, sh[FRM_W-1:1]};
                    end
                end else begin
                    tcnt <= tcnt + 1'b1;
                end
            end

            if (start_ok) begin
                hold_v <= 1'b0;
            end else if (load && !hold_v) begin
                hold_v <= 1'b1;
                hold_d <= load_data;
            end
        end
    end

    assign full = hold_v;
    assign line = busy ? sh[0] : 1'b1;

    // R11
    hold_feed_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(hold_v));

    // R11
    full_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (hold_v && busy && load) |=> $stable(hold_d));

    // R2
    idle_phase_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (tcnt == '0));

    // R2
    bit_range_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> (bit_idx <= last_bit));
endmodule

// File: rtl/mdu_rx.sv
module mdu_rx
    import mdu_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  fcfg_t             fcfg,
    input  logic              rxd,
    input  logic              rd,
    output logic [BYTE_W-1:0] data,
    output logic              ready,
    output logic              ferr,
    output logic              perr
);
    localparam int             TCW    = $clog2(OVS);
    localparam logic [TCW-1:0] T_LAST = TCW'(OVS - 1);
    localparam logic [TCW-1:0] T_MID  = TCW'(OVS / 2 - 1);
    localparam logic [BCW-1:0] LAST_X = BCW'(FRM_W - 1);
    localparam logic [BCW-1:0] LAST_N = BCW'(FRM_W - 2);

    logic [1:0]        sync;
    logic              rx_s;
    rx_st_e            st;
    logic [TCW-1:0]    tcnt;
    logic [BCW-1:0]    idx;
    logic [BCW-1:0]    last_idx;
    logic [FRM_W-1:0]  shr;
    logic [FRM_W-1:0]  fr_now;
    logic              smp;
    logic              false_start;
    logic              done;
    logic              accept;
    logic [BYTE_W-1:0] byte_now;
    logic              xval;
    logic              rx_unused;

    assign rx_s        = sync[1];
    assign last_idx    = (fcfg.md || fcfg.pe) ? LAST_X : LAST_N;
    assign smp         = (st == RXS_SHIFT) && tick && (tcnt == T_MID);
    assign false_start = smp && (idx == '0) && rx_s;
    assign done        = smp && !false_start && (idx == last_idx);

    always_comb begin
        fr_now      = shr;
        fr_now[idx] = rx_s;
    end

    assign byte_now  = fr_now[BYTE_W:1];
    assign xval      = fr_now[BYTE_W+1];
    assign accept    = !fcfg.md || (xval == fcfg.wk);
    assign rx_unused = ^{fr_now[0], fr_now[FRM_W-1]};

    always_ff @(posedge clk) begin
        if (rst) begin
            sync  <= 2'b11;
            st    <= RXS_IDLE;
            tcnt  <= '0;
            idx   <= '0;
            shr   <= '0;
            data  <= '0;
            ready <= 1'b0;
            ferr  <= 1'b0;
            perr  <= 1'b0;
        end else begin
            sync <= {sync[0], rxd};
            case (st)
                RXS_IDLE: begin
                    if (tick && !rx_s) begin
                        st   <= RXS_SHIFT;
                        tcnt <= '0;
                        idx  <= '0;
                    end
                end
                default: begin
                    if (tick) begin
                        tcnt <= (tcnt == T_LAST) ? '0 : tcnt + 1'b1;
                        if (tcnt == T_MID) begin
                            if (false_start || idx == last_idx) begin
                                st <= RXS_IDLE;
                            end else begin
                                shr[idx] <= rx_s;
                                idx      <= idx + 1'b1;
                            end
                        end
                    end
                end
            endcase

            if (done && accept) begin
                data  <= byte_now;
                ready <= 1'b1;
                ferr  <= !rx_s;
                perr  <= !fcfg.md && fcfg.pe && (xval != parity_bit(byte_now, fcfg.ev));
            end else if (rd) begin
                ready <= 1'b0;
            end
        end
    end

    // R8
    drop_chk: assert property (@(posedge clk) disable iff (rst)
        (done && fcfg.md && xval != fcfg.wk) |=> ($stable(data) && !$rose(ready)));

    // R5
    ready_src_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ready) |-> $past(done));

    // R12
    false_start_chk: assert property (@(posedge clk) disable iff (rst)
        false_start |=> (st == RXS_IDLE && $stable(data)));
endmodule

// File: rtl/mdrop_uart.sv
module mdrop_uart
    import mdu_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sclk_in,
    input  logic              lcr_we,
    input  logic [LCR_W-1:0]  lcr_wdata,
    input  logic              tx_load,
    input  logic [BYTE_W-1:0] tx_byte,
    output logic              tx_full,
    output logic              txd_o,
    output logic              txd_oe,
    input  logic              rxd,
    input  logic              rx_read,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              rx_ready,
    output logic              rx_frame_err,
    output logic              rx_parity_err
);
    lcr_t cfg;
    logic tick;
    logic line;
    logic lcr_unused;

    always_ff @(posedge clk) begin
        if (rst)         cfg <= LCR_RST;
        else if (lcr_we) cfg <= lcr_t'(lcr_wdata);
    end

    assign lcr_unused = cfg.mode[0];

    mdu_tick_gen u_tick (
        .clk     (clk),
        .rst     (rst),
        .ext_clk (sclk_in),
        .sel     (cfg.clk_sel),
        .div     (cfg.div),
        .tick    (tick)
    );

    mdu_tx #(.OVS(OVS)) u_tx (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .fcfg      (tx_view(cfg)),
        .load      (tx_load),
        .load_data (tx_byte),
        .full      (tx_full),
        .line      (line)
    );

    mdu_rx #(.OVS(OVS)) u_rx (
        .clk   (clk),
        .rst   (rst),
        .tick  (tick),
        .fcfg  (rx_view(cfg)),
        .rxd   (rxd),
        .rd    (rx_read),
        .data  (rx_byte),
        .ready (rx_ready),
        .ferr  (rx_frame_err),
        .perr  (rx_parity_err)
    );

    assign txd_o  = cfg.od_en ? 1'b0  : line;
    assign txd_oe = cfg.od_en ? ~line : 1'b1;

    // R10
    release_chk: assert property (@(posedge clk) disable iff (rst)
        !txd_oe |-> cfg.od_en);

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        $past(rst) |-> (!tx_full && !rx_ready));
endmodule

// File: tb/test_mdrop_uart.sv
module test_mdrop_uart;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sclk_in = 1'b0;
    logic        lcr_we = 1'b0;
    logic [15:0] lcr_wdata = '0;
    logic        tx_load = 1'b0;
    logic [7:0]  tx_byte = '0;
    logic        rxd = 1'b1;
    logic        rx_read = 1'b0;
    logic        tx_full, txd_o, txd_oe, rx_ready, rx_frame_err, rx_parity_err;
    logic [7:0]  rx_byte;

    int   n_chk = 0;
    int   n_fail = 0;
    bit   model_on = 1'b0;
    bit   exp_q[$];
    bit   exp_b;
    logic [15:0] cur_cfg = 16'h0080;
    logic line;

    always #10 clk = ~clk;

    initial forever begin
        repeat (2) @(negedge clk);
        sclk_in = ~sclk_in;
    end

    mdrop_uart i_mdrop_uart (
        .clk(clk), .rst(rst), .sclk_in(sclk_in), .lcr_we(lcr_we), .lcr_wdata(lcr_wdata),
        .tx_load(tx_load), .tx_byte(tx_byte), .tx_full(tx_full), .txd_o(txd_o), .txd_oe(txd_oe),
        .rxd(rxd), .rx_read(rx_read), .rx_byte(rx_byte), .rx_ready(rx_ready),
        .rx_frame_err(rx_frame_err), .rx_parity_err(rx_parity_err)
    );

    assign line = txd_oe ? txd_o : 1'b1;

    function automatic logic [15:0] mk(logic [1:0] mode, logic pe, logic ev, logic [1:0] sel,
                                       logic od, logic txw, logic rxw, logic [6:0] dv);
        return {dv, rxw, txw, od, sel, ev, pe, mode};
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp, string what);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Cycle reference model of the transmit line
    always @(negedge clk) begin
        if (model_on) begin
            exp_b = (exp_q.size() != 0) ? exp_q.pop_front() : 1'b1;
            check("R2", line, exp_b, "txd line vs model");
            if (cur_cfg[6] && txd_oe) check("R10", txd_o, 1'b0, "open drain drives low only");
        end
    end

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic push_frame(logic [7:0] d);
        bit b[$];
        b.push_back(1'b0);
        for (int i = 0; i < 8; i++) b.push_back(d[i]);
        if (cur_cfg[1])      b.push_back(cur_cfg[7]);
        else if (cur_cfg[2]) b.push_back(cur_cfg[3] ? ^d : ~^d);
        b.push_back(1'b1);
        exp_q.push_back(1'b1);
        foreach (b[k]) repeat (16) exp_q.push_back(b[k]);
    endtask

    task automatic wr_cfg(logic [15:0] v);
        step();
        lcr_we = 1'b1;
        lcr_wdata = v;
        cur_cfg = v;
        step();
        lcr_we = 1'b0;
    endtask

    task automatic send(logic [7:0] d, bit expect_sent);
        step();
        tx_load = 1'b1;
        tx_byte = d;
        if (expect_sent) push_frame(d);
        step();
        tx_load = 1'b0;
    endtask

    task automatic wait_tx();
        while (exp_q.size() != 0) step();
        repeat (3) step();
    endtask

    task automatic rx_frame(logic [7:0] d, bit xp, bit xv, bit stopv);
        rxd = 1'b0;
        repeat (16) step();
        for (int i = 0; i < 8; i++) begin
            rxd = d[i];
            repeat (16) step();
        end
        if (xp) begin
            rxd = xv;
            repeat (16) step();
        end
        rxd = stopv;
        repeat (16) step();
        rxd = 1'b1;
        repeat (30) step();
    endtask

    task automatic rx_ack();
        step();
        rx_read = 1'b1;
        step();
        rx_read = 1'b0;
    endtask

    task automatic start_len(logic [15:0] cfgv, int lo, int hi, string what);
        int n;
        int guard;
        wr_cfg(cfgv);
        send(8'h01, 1'b0);
        guard = 0;
        while (line !== 1'b0 && guard < 1000) begin step(); guard++; end
        n = 0;
        while (line === 1'b0 && n < 1000) begin step(); n++; end
        n_chk++;
        if (n < lo || n > hi) begin
            n_fail++;
            $display("FAIL R9 %s: actual %0d expected %0d..%0d", what, n, lo, hi);
        end
        repeat (20 * hi) step();
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (5) step();
        rst = 1'b0;
        step();
        // R1
        check("R1", line, 1'b1, "idle line");
        check("R1", txd_oe, 1'b1, "idle drive");
        check("R1", tx_full, 1'b0, "tx_full");
        check("R1", rx_ready, 1'b0, "rx_ready");

        model_on = 1'b1;
        // R2 plain frames
        send(8'hA5, 1'b1);
        wait_tx();
        send(8'h3C, 1'b1);
        wait_tx();

        // R11 back-to-back and ignored load
        send(8'h11, 1'b1);
        repeat (20) step();
        send(8'h22, 1'b1);
        check("R11", tx_full, 1'b1, "holding register full");
        send(8'h33, 1'b0);
        wait_tx();
        check("R11", tx_full, 1'b0, "holding register drained");

        // R3 even then odd parity
        wr_cfg(mk(2'b00, 1'b1, 1'b1, 2'b00, 1'b0, 1'b1, 1'b0, 7'd0));
        send(8'h07, 1'b1);
        wait_tx();
        wr_cfg(mk(2'b01, 1'b1, 1'b0, 2'b00, 1'b0, 1'b1, 1'b0, 7'd0));
        send(8'h07, 1'b1);
        wait_tx();

        // R4 wake bit on transmit, parity enable ignored
        wr_cfg(mk(2'b10, 1'b1, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 7'd0));
        send(8'h5A, 1'b1);
        wait_tx();
        wr_cfg(mk(2'b11, 1'b1, 1'b1, 2'b00, 1'b0, 1'b1, 1'b0, 7'd0));
        send(8'hC3, 1'b1);
        wait_tx();

        // R10 open drain
        wr_cfg(mk(2'b00, 1'b0, 1'b0, 2'b00, 1'b1, 1'b1, 1'b0, 7'd0));
        step();
        check("R10", txd_oe, 1'b0, "released when idle");
        send(8'h96, 1'b1);
        wait_tx();

        // R5 normal receive
        wr_cfg(16'h0080);
        rx_frame(8'h4B, 1'b0, 1'b0, 1'b1);
        check("R5", rx_ready, 1'b1, "ready after frame");
        check("R5", rx_byte, 8'h4B, "received byte");
        check("R7", rx_frame_err, 1'b0, "good stop bit");
        rx_ack();
        check("R5", rx_ready, 1'b0, "ready cleared by read");

        // R6 parity check
        wr_cfg(mk(2'b00, 1'b1, 1'b1, 2'b00, 1'b0, 1'b1, 1'b0, 7'd0));
        rx_frame(8'h0F, 1'b1, 1'b0, 1'b1);
        check("R6", rx_byte, 8'h0F, "parity frame byte");
        check("R6", rx_parity_err, 1'b0, "correct parity");
        rx_ack();
        rx_frame(8'h0F, 1'b1, 1'b1, 1'b1);
        check("R6", rx_parity_err, 1'b1, "wrong parity");
        rx_ack();

        // R7 framing error
        wr_cfg(16'h0080);
        rx_frame(8'h81, 1'b0, 1'b0, 1'b0);
        check("R7", rx_frame_err, 1'b1, "low stop bit");
        check("R7", rx_byte, 8'h81, "byte with framing error");
        rx_ack();

        // R12 glitch rejection
        rxd = 1'b0;
        repeat (4) step();
        rxd = 1'b1;
        repeat (100) step();
        check("R12", rx_ready, 1'b0, "glitch ignored");
        rx_frame(8'h66, 1'b0, 1'b0, 1'b1);
        check("R12", rx_byte, 8'h66, "frame after glitch");
        check("R12", rx_frame_err, 1'b0, "frame after glitch clean");
        rx_ack();

        // R8 multidrop filter, address frames selected
        wr_cfg(mk(2'b10, 1'b1, 1'b0, 2'b00, 1'b0, 1'b1, 1'b1, 7'd0));
        rx_frame(8'h12, 1'b1, 1'b0, 1'b1);
        check("R8", rx_ready, 1'b0, "data frame dropped");
        check("R8", rx_byte, 8'h66, "holding register kept");
        rx_frame(8'h34, 1'b1, 1'b1, 1'b1);
        check("R8", rx_ready, 1'b1, "address frame kept");
        check("R8", rx_byte, 8'h34, "address byte");
        check("R4", rx_parity_err, 1'b0, "parity ignored in multidrop");
        rx_ack();
        // R8 data frames selected
        wr_cfg(mk(2'b10, 1'b0, 1'b0, 2'b00, 1'b0, 1'b1, 1'b0, 7'd0));
        rx_frame(8'h56, 1'b1, 1'b1, 1'b1);
        check("R8", rx_ready, 1'b0, "address frame dropped");
        check("R8", rx_byte, 8'h34, "holding register kept again");
        rx_frame(8'h56, 1'b1, 1'b0, 1'b1);
        check("R8", rx_byte, 8'h56, "data byte");
        rx_ack();

        // R9 transfer clock selection
        model_on = 1'b0;
        start_len(mk(2'b00, 1'b0, 1'b0, 2'b01, 1'b0, 1'b1, 1'b0, 7'd2), 46, 48, "bus clock / 3");
        start_len(mk(2'b00, 1'b0, 1'b0, 2'b10, 1'b0, 1'b1, 1'b0, 7'd0), 61, 64, "external clock");
        start_len(mk(2'b00, 1'b0, 1'b0, 2'b11, 1'b0, 1'b1, 1'b0, 7'd1), 121, 128, "external clock / 2");

        summary();
        $finish;
    end
endmodule